// File: doc/BRIEF.md
# Four-Way Set-Associative Data Cache Controller

This block sits between a processor load/store port and a main-memory port that moves whole lines. It keeps copies of recently used lines in four-way set-associative storage built from register arrays. It answers hits locally, fetches missing lines, and picks a victim among the four ways of a set with a three-bit pseudo-LRU tree. A victim is written back first only when it holds modified data.

Two mode inputs are set at run time. `mode_wb` chooses between write-back and write-through. `mode_nocache` sends every access straight to memory. Two maintenance commands are provided. One discards every line without saving anything. The other first writes every modified line to memory and then discards all lines. The processor port is stalled while either command runs.

The controller is one state machine with these states:
- `S_IDLE`: accepts a request or a command.
- `S_LOOKUP`: compares tags.
- `S_WRBACK`: saves a dirty victim.
- `S_REFILL`: fetches a line.
- `S_MEMWR`: writes a single word to memory.
- `S_BYPRD`: reads memory without the cache.
- `S_DONE`: returns the response.
- `S_FLSCAN` and `S_FLWR`: walk through the lines and save dirty ones.
- `S_INVAL`: clears everything in one cycle.

The transitions are:
- `S_IDLE` to `S_FLSCAN` on a flush, to `S_INVAL` on an invalidate, to `S_MEMWR` or `S_BYPRD` on a bypassed write or read, and to `S_LOOKUP` otherwise.
- `S_LOOKUP` to `S_DONE` on a read hit or a write-back write hit.
- `S_LOOKUP` to `S_MEMWR` on any write-through write.
- `S_LOOKUP` to `S_WRBACK` on a miss with a dirty victim, and to `S_REFILL` on a miss with a clean or empty victim.
- `S_WRBACK` to `S_REFILL`, and `S_REFILL`, `S_MEMWR` and `S_BYPRD` to `S_DONE`, each on `mem_ack`.
- `S_DONE` and `S_INVAL` to `S_IDLE`.
- `S_FLSCAN` to `S_FLWR` when it finds a dirty line, and `S_FLWR` back to `S_FLSCAN` on `mem_ack`.
- `S_FLSCAN` to `S_IDLE` after the last line.

Top module: `sa_dcache`

## Requirements
- R1: After reset, every line is invalid, write-back is the mode, `req_ready` is 1, and `rsp_valid` and `mem_req` are 0.
- R2: The word address splits as tag (upper bits), set (next `log2(SETS)` bits) and word-in-line (low `log2(LINE_WORDS)` bits). The default is 6/2/2 bits. A read that matches the tag of a valid way in its set returns the stored word with no memory transfer, and at most one way ever matches.
- R3: A read miss fetches the whole line from memory with one read transfer, installs it, and returns the requested word. Later reads of any word in that line hit.
- R4: In write-back mode (`mode_wb`=1), a write hit updates only the cache and marks the line dirty, with no memory transfer.
- R5: On a miss, a valid dirty victim is written to memory as a full line before the refill. A clean or invalid victim is not written.
- R6: An invalid way, lowest index first, is filled before any valid way is replaced. Otherwise the victim follows a per-set tree {b2,b1,b0}. If b0=0 the victim is way b1, otherwise way 2+b2. Every hit and every fill of way w sets b0=1 and b1=(w==0) when w<2, and sets b0=0 and b2=(w==2) when w>=2.
- R7: In write-through mode (`mode_wb`=0), every write sends one word to memory, with `mem_wmask` bit i enabling word i. A hit also updates the cached word, and no line ever becomes dirty.
- R8: A write-through write miss writes memory only and does not allocate a line.
- R9: A write-back write miss fetches the line, merges the written word, and leaves the line dirty.
- R10: With `mode_nocache`=1, every read and every write makes its own memory transfer, and no line is allocated.
- R11: `cmd_inval` clears every valid and dirty bit without any memory write, so modified data is discarded.
- R12: `cmd_flush` writes every dirty line to memory and then clears all lines. `req_ready` stays 0 until the flush is done.
- R13: Once raised, `mem_req` and its address, direction and data stay stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_nocache | input | 1 | 1: all accesses bypass the cache |
| mode_wb | input | 1 | 1: write-back, 0: write-through |
| cmd_inval | input | 1 | Invalidate all lines (sampled when idle) |
| cmd_flush | input | 1 | Write back dirty lines, then invalidate all (sampled when idle) |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_we | input | 1 | 1: write, 0: read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with `rsp_valid` |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1: memory write |
| mem_addr | output | ADDR_W-log2(LINE_WORDS) | Line address |
| mem_wmask | output | LINE_WORDS | Per-word write enable |
| mem_wline | output | DATA_W*LINE_WORDS | Line write data |
| mem_ack | input | 1 | One-cycle transfer completion |
| mem_rline | input | DATA_W*LINE_WORDS | Line read data, valid with `mem_ack` |

## Verification
The assertions check several properties on every cycle: that at most one way matches a lookup, that the memory request is held stable until it is acknowledged, that a line can only become dirty during a write-back access, that no line survives the end of a flush or an invalidate, and that a bypassed read leaves the valid bits untouched. Other behaviour is visible only in the bench scenarios, which count memory transfers and compare data against a model of memory. These scenarios cover the exact pseudo-LRU victim order where it differs from true LRU, dirty data reaching memory only on eviction or flush, data lost on invalidate, the word-masked write-through update and the lack of allocation on bypass and on write-through write misses.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
    localparam int NWAYS = 4;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LOOKUP,
        S_WRBACK,
        S_REFILL,
        S_MEMWR,
        S_BYPRD,
        S_DONE,
        S_FLSCAN,
        S_FLWR,
        S_INVAL
    } dc_state_e;
endpackage

// File: rtl/dcache_match.sv
module dcache_match
    import dcache_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        probe_en,
    input  logic [NWAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [NWAYS-1:0]            way_vld,
    input  logic [TAG_W-1:0]            probe,
    output logic                        hit,
    output logic [1:0]                  hit_way
);
    logic [NWAYS-1:0] hit_vec;

    generate
        for (genvar w = 0; w < NWAYS; w++) begin : g_cmp
            assign hit_vec[w] = way_vld[w] && (way_tag[w] == probe);
        end
    endgenerate

    assign hit = |hit_vec;

    always_comb begin
        hit_way = '0;
        for (int w = NWAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = 2'(w);
        end
    end

    // R2: a block may live in only one way of its set
    p_single_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        probe_en |-> $onehot0(hit_vec));
endmodule

// File: rtl/dcache_plru.sv
module dcache_plru (
    input  logic [2:0] tree,
    input  logic [3:0] vld,
    input  logic [1:0] touch,
    output logic [1:0] victim,
    output logic [2:0] tree_nxt
);
    always_comb begin
        if (!vld[0])      victim = 2'd0;
        else if (!vld[1]) victim = 2'd1;
        else if (!vld[2]) victim = 2'd2;
        else if (!vld[3]) victim = 2'd3;
        else if (!tree[0]) victim = tree[1] ? 2'd1 : 2'd0;
        else               victim = tree[2] ? 2'd3 : 2'd2;
    end

    always_comb begin
        tree_nxt = tree;
        if (!touch[1]) begin
            tree_nxt[0] = 1'b1;
            tree_nxt[1] = !touch[0];
        end else begin
            tree_nxt[0] = 1'b0;
            tree_nxt[2] = !touch[0];
        end
    end
endmodule

// File: rtl/sa_dcache.sv
module sa_dcache
    import dcache_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int SETS       = 4
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       mode_nocache,
    input  logic                                       mode_wb,
    input  logic                                       cmd_inval,
    input  logic                                       cmd_flush,
    input  logic                                       req_valid,
    output logic                                       req_ready,
    input  logic                                       req_we,
    input  logic [ADDR_W-1:0]                          req_addr,
    input  logic [DATA_W-1:0]                          req_wdata,
    output logic                                       rsp_valid,
    output logic [DATA_W-1:0]                          rsp_rdata,
    output logic                                       mem_req,
    output logic                                       mem_we,
    output logic [ADDR_W-$clog2(LINE_WORDS)-1:0]       mem_addr,
    output logic [LINE_WORDS-1:0]                      mem_wmask,
    output logic [DATA_W*LINE_WORDS-1:0]               mem_wline,
    input  logic                                       mem_ack,
    input  logic [DATA_W*LINE_WORDS-1:0]               mem_rline
);
    localparam int OFF_W  = $clog2(LINE_WORDS);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int LINE_W = DATA_W * LINE_WORDS;
    localparam int SCAN_W = IDX_W + 2;
    localparam int NLINES = SETS * NWAYS;

    // storage
    logic [LINE_W-1:0] data_q [SETS][NWAYS];
    logic [TAG_W-1:0]  tag_q  [SETS][NWAYS];
    logic [NWAYS-1:0]  vld_q  [SETS];
    logic [NWAYS-1:0]  dty_q  [SETS];
    logic [2:0]        plru_q [SETS];

    // latched request
    dc_state_e         state, nxt;
    logic              we_q, wb_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic [1:0]        vict_q;
    logic [SCAN_W-1:0] scan_q;

    logic [TAG_W-1:0]  tag_r;
    logic [IDX_W-1:0]  idx_r;
    logic [OFF_W-1:0]  off_r;
    assign tag_r = addr_q[ADDR_W-1 -: TAG_W];
    assign idx_r = addr_q[OFF_W +: IDX_W];
    assign off_r = addr_q[OFF_W-1:0];

    logic [IDX_W-1:0]  scan_set;
    logic [1:0]        scan_way;
    logic              scan_last, scan_dirty;
    assign scan_set   = scan_q[SCAN_W-1:2];
    assign scan_way   = scan_q[1:0];
    assign scan_last  = &scan_q;
    assign scan_dirty = vld_q[scan_set][scan_way] && dty_q[scan_set][scan_way];

    logic [NWAYS-1:0][TAG_W-1:0] set_tags;
    logic [NLINES-1:0]           vld_flat, dty_flat;
    generate
        for (genvar w = 0; w < NWAYS; w++) begin : g_settag
            assign set_tags[w] = tag_q[idx_r][w];
        end
        for (genvar s = 0; s < SETS; s++) begin : g_flat
            assign vld_flat[s*NWAYS +: NWAYS] = vld_q[s];
            assign dty_flat[s*NWAYS +: NWAYS] = dty_q[s];
        end
    endgenerate

    logic       hit;
    logic [1:0] hit_way, victim, touch;
    logic [2:0] tree_nxt;

    dcache_match #(.TAG_W(TAG_W)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .probe_en (state == S_LOOKUP),
        .way_tag  (set_tags),
        .way_vld  (vld_q[idx_r]),
        .probe    (tag_r),
        .hit      (hit),
        .hit_way  (hit_way)
    );

    assign touch = (state == S_LOOKUP) ? hit_way : vict_q;

    dcache_plru u_plru (
        .tree     (plru_q[idx_r]),
        .vld      (vld_q[idx_r]),
        .touch    (touch),
        .victim   (victim),
        .tree_nxt (tree_nxt)
    );

    function automatic logic [DATA_W-1:0] pick(input logic [LINE_W-1:0] l,
                                               input logic [OFF_W-1:0] o);
        return l[o*DATA_W +: DATA_W];
    endfunction

    function automatic logic [LINE_W-1:0] merge(input logic [LINE_W-1:0] l,
                                                input logic [OFF_W-1:0] o,
                                                input logic [DATA_W-1:0] d);
        logic [LINE_W-1:0] r;
        r = l;
        r[o*DATA_W +: DATA_W] = d;
        return r;
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (cmd_flush)      nxt = S_FLSCAN;
                else if (cmd_inval) nxt = S_INVAL;
                else if (req_valid) begin
                    if (mode_nocache) nxt = req_we ? S_MEMWR : S_BYPRD;
                    else              nxt = S_LOOKUP;
                end
            end
            S_LOOKUP: begin
                if (we_q && !wb_q)                           nxt = S_MEMWR;
                else if (hit)                                nxt = S_DONE;
                else if (vld_q[idx_r][victim] && dty_q[idx_r][victim]) nxt = S_WRBACK;
                else                                         nxt = S_REFILL;
            end
            S_WRBACK: if (mem_ack) nxt = S_REFILL;
            S_REFILL: if (mem_ack) nxt = S_DONE;
            S_MEMWR:  if (mem_ack) nxt = S_DONE;
            S_BYPRD:  if (mem_ack) nxt = S_DONE;
            S_DONE:   nxt = S_IDLE;
            S_INVAL:  nxt = S_IDLE;
            S_FLSCAN: begin
                if (scan_dirty)     nxt = S_FLWR;
                else if (scan_last) nxt = S_IDLE;
            end
            S_FLWR:   if (mem_ack) nxt = S_FLSCAN;
            default:  nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = (state == S_IDLE) && !cmd_flush && !cmd_inval;
        rsp_valid = (state == S_DONE);
        rsp_rdata = rdata_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = addr_q[ADDR_W-1:OFF_W];
        mem_wmask = '1;
        mem_wline = {LINE_WORDS{wdata_q}};
        unique case (state)
            S_WRBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {tag_q[idx_r][vict_q], idx_r};
                mem_wline = data_q[idx_r][vict_q];
            end
            S_FLWR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {tag_q[scan_set][scan_way], scan_set};
                mem_wline = data_q[scan_set][scan_way];
            end
            S_MEMWR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wmask = LINE_WORDS'(1) << off_r;
            end
            S_REFILL, S_BYPRD: mem_req = 1'b1;
            default: ;
        endcase
    end

    // control and bookkeeping registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s]  <= '0;
                dty_q[s]  <= '0;
                plru_q[s] <= '0;
            end
            we_q    <= 1'b0;
            wb_q    <= 1'b1;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            vict_q  <= '0;
            scan_q  <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid && req_ready) begin
                    we_q    <= req_we;
                    wb_q    <= mode_wb;
                    addr_q  <= req_addr;
                    wdata_q <= req_wdata;
                end
                S_LOOKUP: begin
                    vict_q <= victim;
                    if (hit) begin
                        plru_q[idx_r] <= tree_nxt;
                        rdata_q       <= pick(data_q[idx_r][hit_way], off_r);
                        if (we_q && wb_q) dty_q[idx_r][hit_way] <= 1'b1;
                    end
                end
                S_REFILL: if (mem_ack) begin
                    vld_q[idx_r][vict_q] <= 1'b1;
                    dty_q[idx_r][vict_q] <= we_q;
                    plru_q[idx_r]        <= tree_nxt;
                    rdata_q              <= pick(mem_rline, off_r);
                end
                S_BYPRD: if (mem_ack) rdata_q <= pick(mem_rline, off_r);
                S_FLSCAN: if (!scan_dirty) begin
                    if (scan_last) begin
                        for (int s = 0; s < SETS; s++) begin
                            vld_q[s] <= '0;
                            dty_q[s] <= '0;
                        end
                        scan_q <= '0;
                    end else begin
                        scan_q <= scan_q + 1'b1;
                    end
                end
                S_FLWR: if (mem_ack) dty_q[scan_set][scan_way] <= 1'b0;
                S_INVAL: begin
                    for (int s = 0; s < SETS; s++) begin
                        vld_q[s] <= '0;
                        dty_q[s] <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // line data and tags
    always_ff @(posedge clk) begin
        if (state == S_LOOKUP && hit && we_q)
            data_q[idx_r][hit_way] <= merge(data_q[idx_r][hit_way], off_r, wdata_q);
        if (state == S_REFILL && mem_ack) begin
            data_q[idx_r][vict_q] <= we_q ? merge(mem_rline, off_r, wdata_q) : mem_rline;
            tag_q[idx_r][vict_q]  <= tag_r;
        end
    end

    // R13: request held until acknowledged
    p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wline) && $stable(mem_wmask)));

    // R7: dirty bits only grow under a write-back access
    p_wt_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(dty_flat) > $past($countones(dty_flat))) |-> $past(wb_q));

    // R12: no line survives the end of a flush
    p_flush_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && $past(state) == S_FLSCAN) |-> (vld_flat == '0));

    // R11: invalidate leaves no valid or dirty line
    p_inval_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && $past(state) == S_INVAL) |-> (vld_flat == '0 && dty_flat == '0));

    // R10: a bypassed read never allocates
    p_bypass_nofill_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BYPRD) |=> $stable(vld_flat));
endmodule

// File: tb/sa_dcache_test.sv
module sa_dcache_test;
    localparam int AW = 10;
    localparam int DW = 32;
    localparam int LW = 4;
    localparam int NW = 1 << AW;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic           rst_n, mode_nocache, mode_wb, cmd_inval, cmd_flush;
    logic           req_valid, req_ready, req_we, rsp_valid;
    logic [AW-1:0]  req_addr;
    logic [DW-1:0]  req_wdata, rsp_rdata;
    logic           mem_req, mem_we, mem_ack;
    logic [AW-3:0]  mem_addr;
    logic [LW-1:0]  mem_wmask;
    logic [DW*LW-1:0] mem_wline, mem_rline;

    sa_dcache uut (
        .clk(clk), .rst_n(rst_n), .mode_nocache(mode_nocache), .mode_wb(mode_wb),
        .cmd_inval(cmd_inval), .cmd_flush(cmd_flush), .req_valid(req_valid),
        .req_ready(req_ready), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wmask(mem_wmask), .mem_wline(mem_wline), .mem_ack(mem_ack),
        .mem_rline(mem_rline)
    );

    logic [DW-1:0] mem  [NW];
    logic [DW-1:0] refm [NW];
    int rd_cnt = 0, wr_cnt = 0, hs_viol = 0;
    int checks = 0, errors = 0;
    int r0, w0;
    bit finished = 0;

    function automatic int A(input int t, input int s, input int w);
        return t * 16 + s * 4 + w;
    endfunction

    // memory responder: one-cycle wait, then a one-cycle ack
    initial begin
        int lat;
        lat = 0;
        mem_ack = 1'b0;
        mem_rline = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req) begin
                if (lat == 1) begin
                    if (mem_we) begin
                        for (int w = 0; w < LW; w++)
                            if (mem_wmask[w]) mem[int'(mem_addr) * LW + w] = mem_wline[w*DW +: DW];
                        wr_cnt++;
                    end else begin
                        for (int w = 0; w < LW; w++)
                            mem_rline[w*DW +: DW] = mem[int'(mem_addr) * LW + w];
                        rd_cnt++;
                    end
                    mem_ack = 1'b1;
                    lat = 0;
                end else lat++;
            end else if (lat != 0) begin
                hs_viol++;
                lat = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic snap();
        r0 = rd_cnt;
        w0 = wr_cnt;
    endtask

    task automatic access(input logic we, input int a, input logic [DW-1:0] wd,
                          output logic [DW-1:0] rd);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = AW'(a); req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
        while (!rsp_valid) @(negedge clk);
        rd = rsp_rdata;
    endtask

    task automatic rd_chk(input int a, input string req);
        logic [DW-1:0] d;
        access(1'b0, a, '0, d);
        chk(d == refm[a], req, d, refm[a]);
    endtask

    task automatic wr(input int a, input logic [DW-1:0] v);
        logic [DW-1:0] d;
        access(1'b1, a, v, d);
    endtask

    task automatic command(input bit flush, input string req);
        while (!req_ready) @(negedge clk);
        if (flush) cmd_flush = 1'b1; else cmd_inval = 1'b1;
        @(negedge clk);
        cmd_flush = 1'b0; cmd_inval = 1'b0;
        chk(req_ready == 1'b0, req, req_ready, 0);
        while (!req_ready) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d, old;
        int bad;
        for (int a = 0; a < NW; a++) begin
            mem[a]  = 32'h5A000000 ^ (a * 32'h00010003);
            refm[a] = mem[a];
        end
        rst_n = 1'b0; mode_nocache = 1'b0; mode_wb = 1'b1;
        cmd_inval = 1'b0; cmd_flush = 1'b0;
        req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1 rsp", rsp_valid, 0);
        chk(mem_req == 1'b0, "R1 memreq", mem_req, 0);

        // R3 fill 16 lines (4 tags x 4 sets), every word checked
        snap();
        for (int t = 0; t < 4; t++)
            for (int s = 0; s < 4; s++)
                for (int w = 0; w < 4; w++) rd_chk(A(t, s, w), "R3 fill data");
        chk(rd_cnt - r0 == 16, "R3 one read per line", rd_cnt - r0, 16);
        chk(wr_cnt - w0 == 0, "R1 clean start no writes", wr_cnt - w0, 0);

        // R2 all hits
        snap();
        for (int t = 0; t < 4; t++)
            for (int s = 0; s < 4; s++)
                for (int w = 0; w < 4; w++) rd_chk(A(t, s, w), "R2 hit data");
        chk(rd_cnt - r0 == 0, "R2 hits no traffic", rd_cnt - r0, 0);

        // R4 write-back write hits on set 0
        snap();
        for (int t = 0; t < 4; t++)
            for (int w = 0; w < 4; w++) begin
                wr(A(t, 0, w), 32'hD0000000 | 32'(A(t, 0, w)));
                refm[A(t, 0, w)] = 32'hD0000000 | 32'(A(t, 0, w));
            end
        for (int t = 0; t < 4; t++)
            for (int w = 0; w < 4; w++) rd_chk(A(t, 0, w), "R4 readback");
        chk(wr_cnt - w0 == 0 && rd_cnt - r0 == 0, "R4 no traffic", wr_cnt - w0 + rd_cnt - r0, 0);
        chk(mem[A(0, 0, 0)] != refm[A(0, 0, 0)], "R4 memory stale", mem[A(0, 0, 0)], 0);

        // R6 pseudo-LRU order in set 1; R5 clean victim not written
        rd_chk(A(1, 1, 0), "R6 touch");
        rd_chk(A(0, 1, 0), "R6 touch");
        snap();
        rd_chk(A(4, 1, 0), "R6 fill tag4");
        chk(rd_cnt - r0 == 1, "R6 tag4 miss", rd_cnt - r0, 1);
        chk(wr_cnt - w0 == 0, "R5 clean victim no write", wr_cnt - w0, 0);
        snap();
        rd_chk(A(0, 1, 1), "R6 hit");
        rd_chk(A(1, 1, 1), "R6 hit");
        rd_chk(A(3, 1, 1), "R6 hit");
        chk(rd_cnt - r0 == 0, "R6 survivors hit (tag2 evicted)", rd_cnt - r0, 0);
        rd_chk(A(2, 1, 0), "R6 refill tag2");
        snap();
        rd_chk(A(4, 1, 2), "R6 tag4 kept");
        chk(rd_cnt - r0 == 0, "R6 tree kept tag4", rd_cnt - r0, 0);
        rd_chk(A(0, 1, 2), "R6 tag0 evicted");
        chk(rd_cnt - r0 == 1, "R6 tree evicted tag0", rd_cnt - r0, 1);

        // R5 dirty victim in set 0 (tag0 by tree) written before refill
        snap();
        rd_chk(A(5, 0, 3), "R5 miss data");
        chk(wr_cnt - w0 == 1 && rd_cnt - r0 == 1, "R5 writeback+refill",
            (wr_cnt - w0) * 16 + rd_cnt - r0, 17);
        bad = 0;
        for (int w = 0; w < 4; w++) if (mem[A(0, 0, w)] != refm[A(0, 0, w)]) bad++;
        chk(bad == 0, "R5 evicted line in memory", bad, 0);

        // R9 write-back write miss allocates and merges
        snap();
        wr(A(6, 2, 1), 32'hABCD0001);
        refm[A(6, 2, 1)] = 32'hABCD0001;
        chk(rd_cnt - r0 == 1 && wr_cnt - w0 == 0, "R9 fetch no write",
            (rd_cnt - r0) * 16 + wr_cnt - w0, 16);
        rd_chk(A(6, 2, 1), "R9 merged word");
        rd_chk(A(6, 2, 0), "R9 neighbour word");
        chk(rd_cnt - r0 == 1, "R9 line allocated", rd_cnt - r0, 1);

        // R12 flush: 4 dirty lines (set0 tags1..3, set2 tag6)
        snap();
        command(1'b1, "R12 stall");
        chk(wr_cnt - w0 == 4, "R12 dirty writes", wr_cnt - w0, 4);
        bad = 0;
        for (int a = 0; a < NW; a++) if (mem[a] != refm[a]) bad++;
        chk(bad == 0, "R12 memory coherent", bad, 0);
        snap();
        rd_chk(A(1, 0, 0), "R12 data after flush");
        chk(rd_cnt - r0 == 1, "R12 invalidated", rd_cnt - r0, 1);

        // R11 invalidate discards dirty data
        snap();
        old = refm[A(1, 0, 0)];
        wr(A(1, 0, 0), 32'h0BAD0BAD);
        command(1'b0, "R11 stall");
        access(1'b0, A(1, 0, 0), '0, d);
        chk(d == old, "R11 data discarded", d, old);
        chk(wr_cnt - w0 == 0, "R11 no writes", wr_cnt - w0, 0);

        // R7/R8 write-through
        mode_wb = 1'b0;
        rd_chk(A(3, 3, 0), "R7 allocate");
        snap();
        wr(A(3, 3, 2), 32'h77770002);
        refm[A(3, 3, 2)] = 32'h77770002;
        chk(wr_cnt - w0 == 1 && rd_cnt - r0 == 0, "R7 one write", wr_cnt - w0, 1);
        chk(mem[A(3, 3, 2)] == 32'h77770002, "R7 memory word", mem[A(3, 3, 2)], 32'h77770002);
        chk(mem[A(3, 3, 1)] == refm[A(3, 3, 1)], "R7 mask neighbour", mem[A(3, 3, 1)], refm[A(3, 3, 1)]);
        rd_chk(A(3, 3, 2), "R7 cache updated");
        chk(rd_cnt - r0 == 0, "R7 hit after write", rd_cnt - r0, 0);
        snap();
        wr(A(7, 3, 0), 32'h88880000);
        refm[A(7, 3, 0)] = 32'h88880000;
        chk(wr_cnt - w0 == 1 && rd_cnt - r0 == 0, "R8 write only",
            (wr_cnt - w0) * 16 + rd_cnt - r0, 16);
        rd_chk(A(7, 3, 0), "R8 data");
        chk(rd_cnt - r0 == 1, "R8 not allocated", rd_cnt - r0, 1);
        snap();
        command(1'b1, "R12 stall wt");
        chk(wr_cnt - w0 == 0, "R7 never dirty", wr_cnt - w0, 0);

        // R10 bypass
        mode_wb = 1'b1;
        mode_nocache = 1'b1;
        snap();
        rd_chk(A(2, 1, 3), "R10 read");
        rd_chk(A(2, 1, 3), "R10 read again");
        chk(rd_cnt - r0 == 2, "R10 each read to memory", rd_cnt - r0, 2);
        wr(A(2, 1, 3), 32'h99990013);
        refm[A(2, 1, 3)] = 32'h99990013;
        chk(wr_cnt - w0 == 1, "R10 write to memory", wr_cnt - w0, 1);
        rd_chk(A(2, 1, 3), "R10 read written");
        chk(rd_cnt - r0 == 3, "R10 no allocation", rd_cnt - r0, 3);
        mode_nocache = 1'b0;
        snap();
        rd_chk(A(2, 1, 3), "R10 cached mode");
        rd_chk(A(2, 1, 3), "R3 cached hit");
        chk(rd_cnt - r0 == 1, "R10 miss then hit", rd_cnt - r0, 1);

        chk(hs_viol == 0, "R13 handshake", hs_viol, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule